// File: doc/BRIEF.md
# Two-Bank Memory with a Full-Range Merged Port

This block is a logical memory of 1024 words of 32 bits, stored in two physical banks of 512 words. Each bank has its own narrow ports: a read port and a write port that address only that bank. Alongside them sits one wide read-write port that covers the whole logical address space. A merge stage decodes the upper address bits of each wide access and steers it to one bank. For a read, it returns that bank's data one cycle later.

Every read port has a fixed latency of one cycle. A read request made in cycle N delivers data and a valid flag in cycle N+1. A narrow port and the wide port can write the same bank in the same cycle. When that happens the narrow port takes the bank's write path and the wide write is dropped, so nothing needs to arbitrate. Two parameters set the bank count and the bank depth.

Top module: `banked_mem_merged`

## Requirements
- R1: While reset is high, and on the cycle after it falls, every read-valid output (each narrow `nr_rvalid` bit and `wd_rvalid`) is low. Reset does not touch stored words.
- R2: A narrow read of bank b at offset o, requested in cycle N, drives `nr_rvalid[b]` high and `nr_rdata` slice b to the stored word in cycle N+1.
- R3: For the wide port, address bit 9 (the top `$clog2(BANKS)` bits) selects the bank: bank 0 holds logical addresses 0–511 and bank 1 holds 512–1023. The low 9 bits are the offset in the bank, so a wide write to address A can be read back through the narrow port of bank A[9] at offset A[8:0].
- R4: A wide read in cycle N returns the word of the bank chosen in cycle N, in cycle N+1, even when the cycle N+1 access goes to the other bank.
- R5: If a narrow write and a wide write target the same bank in one cycle, only the narrow write is stored. This holds at the same offset and at different offsets.
- R6: A wide write to one bank and a narrow write to another bank in the same cycle are both stored.
- R7: A read and a write of the same word in the same cycle return the word as it was before that write.
- R8: `wd_rvalid` is high in cycle N+1 only when cycle N held a wide read (`wd_en`=1, `wd_we`=0). A wide write or an idle cycle leaves it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nr_re | input | BANKS | Narrow read request, one bit per bank |
| nr_raddr | input | BANKS*9 | Narrow read offsets; bank b in slice b |
| nr_rdata | output | BANKS*32 | Narrow read data; bank b in slice b |
| nr_rvalid | output | BANKS | Narrow read data valid, one bit per bank |
| nr_we | input | BANKS | Narrow write enable, one bit per bank |
| nr_waddr | input | BANKS*9 | Narrow write offsets |
| nr_wdata | input | BANKS*32 | Narrow write data |
| wd_en | input | 1 | Wide port access enable |
| wd_we | input | 1 | Wide port write (1) or read (0) |
| wd_addr | input | 10 | Wide port logical address |
| wd_wdata | input | 32 | Wide port write data |
| wd_rdata | output | 32 | Wide port read data |
| wd_rvalid | output | 1 | Wide port read data valid |

## Verification
The bench issues wide reads back to back to alternating banks. A merge that picks the read data with the current select instead of the delayed one would hand each reply from the wrong bank. Addresses 511 and 512 sit on the bank boundary; an off-by-one bank decode would store those words in the other bank, and the narrow-port readback would expose it. The bench drives colliding writes at the same offset and at different offsets. There, a design with the wrong priority would keep the wide data, and a design that merges the writes would corrupt a neighbouring word. A wide write followed by a check of `wd_rvalid` catches a valid flag raised for writes.

// File: rtl/banked_mem_pkg.sv
package banked_mem_pkg;

    // Kind of access presented on the wide port in one cycle
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_e;

    // Bits needed to name one of n banks (at least one)
    function automatic int sel_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Bits the bank index adds to a logical address (zero for one bank)
    function automatic int extra_bits(input int n);
        return (n > 1) ? $clog2(n) : 0;
    endfunction

    function automatic acc_kind_e decode_kind(input logic en, input logic we);
        if (!en)     return ACC_IDLE;
        else if (we) return ACC_WRITE;
        else         return ACC_READ;
    endfunction

endpackage

// File: rtl/banked_mem_bank.sv
module banked_mem_bank
    import banked_mem_pkg::*;
#(
    parameter int DEPTH  = 512,
    parameter int DATA_W = 32,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    // narrow read
    input  logic              n_re,
    input  logic [AW-1:0]     n_raddr,
    output logic [DATA_W-1:0] n_rdata,
    output logic              n_rvalid,
    // narrow write
    input  logic              n_we,
    input  logic [AW-1:0]     n_waddr,
    input  logic [DATA_W-1:0] n_wdata,
    // merged-port leg
    input  logic              m_re,
    input  logic              m_we,
    input  logic [AW-1:0]     m_addr,
    input  logic [DATA_W-1:0] m_wdata,
    output logic [DATA_W-1:0] m_rdata
);

    logic [DATA_W-1:0] store [DEPTH];

    // Single write path: the narrow port owns it when both ask
    logic              wr_fire;
    logic [AW-1:0]     wr_addr;
    logic [DATA_W-1:0] wr_data;

    always_comb begin
        wr_fire = n_we | m_we;
        wr_addr = n_we ? n_waddr : m_addr;
        wr_data = n_we ? n_wdata : m_wdata;
    end

    always_ff @(posedge clk) begin
        if (wr_fire) store[wr_addr] <= wr_data;
    end

    // Read-first registered reads, one per port
    always_ff @(posedge clk) begin
        if (n_re) n_rdata <= store[n_raddr];
        if (m_re) m_rdata <= store[m_addr];
    end

    always_ff @(posedge clk) begin
        if (rst) n_rvalid <= 1'b0;
        else     n_rvalid <= n_re;
    end

    // R2
    nr_latency_chk: assert property (@(posedge clk) disable iff (rst)
        n_re |=> n_rvalid);

    // R2
    nr_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !n_re |=> !n_rvalid);

endmodule

// File: rtl/banked_mem_merge.sv
module banked_mem_merge
    import banked_mem_pkg::*;
#(
    parameter int BANKS  = 2,
    parameter int DEPTH  = 512,
    parameter int DATA_W = 32,
    localparam int AW    = $clog2(DEPTH),
    localparam int SW    = sel_bits(BANKS),
    localparam int LAW   = AW + extra_bits(BANKS)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wd_en,
    input  logic                    wd_we,
    input  logic [LAW-1:0]          wd_addr,
    input  logic [DATA_W-1:0]       wd_wdata,
    output logic [DATA_W-1:0]       wd_rdata,
    output logic                    wd_rvalid,
    // legs towards the banks
    output logic [BANKS-1:0]        leg_re,
    output logic [BANKS-1:0]        leg_we,
    output logic [AW-1:0]           leg_addr,
    output logic [DATA_W-1:0]       leg_wdata,
    input  logic [BANKS*DATA_W-1:0] leg_rdata
);

    acc_kind_e     kind;
    logic [SW-1:0] sel_now;
    logic [SW-1:0] sel_q;

    assign kind      = decode_kind(wd_en, wd_we);
    assign leg_addr  = wd_addr[AW-1:0];
    assign leg_wdata = wd_wdata;

    generate
        if (BANKS > 1) begin : g_multi
            assign sel_now = wd_addr[LAW-1:AW];
        end else begin : g_single
            assign sel_now = '0;
        end
    endgenerate

    generate
        for (genvar b = 0; b < BANKS; b++) begin : g_leg
            assign leg_re[b] = (kind == ACC_READ)  && (sel_now == SW'(b));
            assign leg_we[b] = (kind == ACC_WRITE) && (sel_now == SW'(b));
        end
    endgenerate

    // Select delayed to match the one-cycle bank read
    always_ff @(posedge clk) begin
        if (kind == ACC_READ) sel_q <= sel_now;
    end

    always_ff @(posedge clk) begin
        if (rst) wd_rvalid <= 1'b0;
        else     wd_rvalid <= (kind == ACC_READ);
    end

    assign wd_rdata = leg_rdata[sel_q*DATA_W +: DATA_W];

    // R8
    wd_rvalid_chk: assert property (@(posedge clk) disable iff (rst)
        (wd_en && !wd_we) |=> wd_rvalid);

    // R8
    wd_novalid_chk: assert property (@(posedge clk) disable iff (rst)
        (!wd_en || wd_we) |=> !wd_rvalid);

    // R3
    one_leg_chk: assert property (@(posedge clk) disable iff (rst)
        wd_en |-> ($countones(leg_re | leg_we) == 1));

    // R3
    leg_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(leg_re | leg_we));

endmodule

// File: rtl/banked_mem_merged.sv
module banked_mem_merged
    import banked_mem_pkg::*;
#(
    parameter int BANKS  = 2,
    parameter int DEPTH  = 512,
    parameter int DATA_W = 32,
    localparam int AW    = $clog2(DEPTH),
    localparam int LAW   = AW + extra_bits(BANKS)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [BANKS-1:0]        nr_re,
    input  logic [BANKS*AW-1:0]     nr_raddr,
    output logic [BANKS*DATA_W-1:0] nr_rdata,
    output logic [BANKS-1:0]        nr_rvalid,
    input  logic [BANKS-1:0]        nr_we,
    input  logic [BANKS*AW-1:0]     nr_waddr,
    input  logic [BANKS*DATA_W-1:0] nr_wdata,
    input  logic                    wd_en,
    input  logic                    wd_we,
    input  logic [LAW-1:0]          wd_addr,
    input  logic [DATA_W-1:0]       wd_wdata,
    output logic [DATA_W-1:0]       wd_rdata,
    output logic                    wd_rvalid
);

    logic [BANKS-1:0]        leg_re;
    logic [BANKS-1:0]        leg_we;
    logic [AW-1:0]           leg_addr;
    logic [DATA_W-1:0]       leg_wdata;
    logic [BANKS*DATA_W-1:0] leg_rdata;

    banked_mem_merge #(
        .BANKS (BANKS),
        .DEPTH (DEPTH),
        .DATA_W(DATA_W)
    ) u_merge (
        .clk      (clk),
        .rst      (rst),
        .wd_en    (wd_en),
        .wd_we    (wd_we),
        .wd_addr  (wd_addr),
        .wd_wdata (wd_wdata),
        .wd_rdata (wd_rdata),
        .wd_rvalid(wd_rvalid),
        .leg_re   (leg_re),
        .leg_we   (leg_we),
        .leg_addr (leg_addr),
        .leg_wdata(leg_wdata),
        .leg_rdata(leg_rdata)
    );

    generate
        for (genvar b = 0; b < BANKS; b++) begin : g_bank
            banked_mem_bank #(
                .DEPTH (DEPTH),
                .DATA_W(DATA_W)
            ) u_bank (
                .clk     (clk),
                .rst     (rst),
                .n_re    (nr_re[b]),
                .n_raddr (nr_raddr[b*AW +: AW]),
                .n_rdata (nr_rdata[b*DATA_W +: DATA_W]),
                .n_rvalid(nr_rvalid[b]),
                .n_we    (nr_we[b]),
                .n_waddr (nr_waddr[b*AW +: AW]),
                .n_wdata (nr_wdata[b*DATA_W +: DATA_W]),
                .m_re    (leg_re[b]),
                .m_we    (leg_we[b]),
                .m_addr  (leg_addr),
                .m_wdata (leg_wdata),
                .m_rdata (leg_rdata[b*DATA_W +: DATA_W])
            );
        end
    endgenerate

endmodule

// File: tb/test_banked_mem_merged.sv
module test_banked_mem_merged;

    localparam int BANKS = 2;
    localparam int DEPTH = 512;
    localparam int DW    = 32;
    localparam int AW    = 9;
    localparam int LAW   = 10;

    logic                 clk = 1'b0;
    logic                 rst;
    logic [BANKS-1:0]     nr_re;
    logic [BANKS*AW-1:0]  nr_raddr;
    logic [BANKS*DW-1:0]  nr_rdata;
    logic [BANKS-1:0]     nr_rvalid;
    logic [BANKS-1:0]     nr_we;
    logic [BANKS*AW-1:0]  nr_waddr;
    logic [BANKS*DW-1:0]  nr_wdata;
    logic                 wd_en;
    logic                 wd_we;
    logic [LAW-1:0]       wd_addr;
    logic [DW-1:0]        wd_wdata;
    logic [DW-1:0]        wd_rdata;
    logic                 wd_rvalid;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    banked_mem_merged #(.BANKS(BANKS), .DEPTH(DEPTH), .DATA_W(DW)) i_banked_mem_merged (
        .clk(clk), .rst(rst),
        .nr_re(nr_re), .nr_raddr(nr_raddr), .nr_rdata(nr_rdata), .nr_rvalid(nr_rvalid),
        .nr_we(nr_we), .nr_waddr(nr_waddr), .nr_wdata(nr_wdata),
        .wd_en(wd_en), .wd_we(wd_we), .wd_addr(wd_addr), .wd_wdata(wd_wdata),
        .wd_rdata(wd_rdata), .wd_rvalid(wd_rvalid)
    );

    // Table: logical address and the word written there through the wide port
    typedef struct packed {
        logic [LAW-1:0] addr;
        logic [DW-1:0]  data;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{10'd0,    32'h0000_0001},
        '{10'd511,  32'h1FF0_1FF0},
        '{10'd512,  32'h2000_0200},
        '{10'd1023, 32'h3FF3_FF00},
        '{10'd100,  32'hDEAD_BEEF},
        '{10'd612,  32'hCAFE_F00D},
        '{10'd255,  32'h5555_AAAA},
        '{10'd767,  32'hAAAA_5555}
    };

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        nr_re = '0; nr_we = '0; nr_raddr = '0; nr_waddr = '0; nr_wdata = '0;
        wd_en = 1'b0; wd_we = 1'b0; wd_addr = '0; wd_wdata = '0;
    endtask

    task automatic wide_write(input logic [LAW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        idle(); wd_en = 1'b1; wd_we = 1'b1; wd_addr = a; wd_wdata = d;
        @(negedge clk);
        idle();
    endtask

    task automatic narrow_write(input int b, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        idle(); nr_we[b] = 1'b1; nr_waddr[b*AW +: AW] = a; nr_wdata[b*DW +: DW] = d;
        @(negedge clk);
        idle();
    endtask

    task automatic wide_read(input string req, input logic [LAW-1:0] a, input logic [DW-1:0] exp);
        @(negedge clk);
        idle(); wd_en = 1'b1; wd_addr = a;
        @(negedge clk);
        idle();
        check(req, {31'd0, wd_rvalid}, 32'd1);
        check(req, wd_rdata, exp);
    endtask

    task automatic narrow_read(input string req, input int b, input logic [AW-1:0] a,
                               input logic [DW-1:0] exp);
        @(negedge clk);
        idle(); nr_re[b] = 1'b1; nr_raddr[b*AW +: AW] = a;
        @(negedge clk);
        idle();
        check(req, {31'd0, nr_rvalid[b]}, 32'd1);
        check(req, nr_rdata[b*DW +: DW], exp);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        idle();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        // R1: valids low during reset
        check("R1 reset nr_rvalid", {30'd0, nr_rvalid}, 32'd0);
        check("R1 reset wd_rvalid", {31'd0, wd_rvalid}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", {29'd0, nr_rvalid, wd_rvalid}, 32'd0);

        // R3 table: write wide, read back wide and through the owning narrow port
        for (int i = 0; i < NV; i++) begin
            wide_write(VECS[i].addr, VECS[i].data);
        end
        for (int i = 0; i < NV; i++) begin
            wide_read("R3 wide readback", VECS[i].addr, VECS[i].data);
            narrow_read("R3 narrow of bank", int'(VECS[i].addr[9]), VECS[i].addr[8:0], VECS[i].data);
        end

        // R2: narrow write then narrow read on bank 1
        narrow_write(1, 9'd7, 32'h7777_0001);
        narrow_read("R2 narrow latency", 1, 9'd7, 32'h7777_0001);
        wide_read("R3 narrow-written word via wide", 10'd519, 32'h7777_0001);

        // R4: back-to-back wide reads alternating banks
        wide_write(10'd5,   32'h0000_00A5);
        wide_write(10'd517, 32'h0000_00B5);
        @(negedge clk);
        idle(); wd_en = 1'b1; wd_addr = 10'd5;
        @(negedge clk);
        check("R4 first of pair", wd_rdata, 32'h0000_00A5);
        wd_addr = 10'd517;
        @(negedge clk);
        check("R4 second of pair", wd_rdata, 32'h0000_00B5);
        wd_addr = 10'd5;
        @(negedge clk);
        check("R4 third of pair", wd_rdata, 32'h0000_00A5);
        idle();

        // R8: wide write leaves valid low
        @(negedge clk);
        wd_en = 1'b1; wd_we = 1'b1; wd_addr = 10'd60; wd_wdata = 32'h6060_6060;
        @(negedge clk);
        idle();
        check("R8 no valid after write", {31'd0, wd_rvalid}, 32'd0);
        @(negedge clk);
        check("R8 no valid when idle", {31'd0, wd_rvalid}, 32'd0);

        // R5: collision at different offsets in bank 0
        wide_write(10'd10, 32'h0000_0AAA);
        @(negedge clk);
        idle(); wd_en = 1'b1; wd_we = 1'b1; wd_addr = 10'd10; wd_wdata = 32'h0000_0111;
        nr_we[0] = 1'b1; nr_waddr[0 +: AW] = 9'd20; nr_wdata[0 +: DW] = 32'h0000_0222;
        @(negedge clk);
        idle();
        narrow_read("R5 narrow write stored", 0, 9'd20, 32'h0000_0222);
        wide_read("R5 wide write dropped", 10'd10, 32'h0000_0AAA);

        // R5: collision at the same offset in bank 1
        @(negedge clk);
        idle(); wd_en = 1'b1; wd_we = 1'b1; wd_addr = 10'd542; wd_wdata = 32'hBAD0_BAD0;
        nr_we[1] = 1'b1; nr_waddr[AW +: AW] = 9'd30; nr_wdata[DW +: DW] = 32'h600D_600D;
        @(negedge clk);
        idle();
        wide_read("R5 same offset narrow wins", 10'd542, 32'h600D_600D);

        // R6: wide to bank 1, narrow to bank 0, same cycle
        @(negedge clk);
        idle(); wd_en = 1'b1; wd_we = 1'b1; wd_addr = 10'd552; wd_wdata = 32'h0000_0333;
        nr_we[0] = 1'b1; nr_waddr[0 +: AW] = 9'd40; nr_wdata[0 +: DW] = 32'h0000_0444;
        @(negedge clk);
        idle();
        narrow_read("R6 narrow bank0 stored", 0, 9'd40, 32'h0000_0444);
        narrow_read("R6 wide bank1 stored", 1, 9'd40, 32'h0000_0333);

        // R7: read-first when reading and writing the same word
        wide_write(10'd50, 32'h0000_0050);
        @(negedge clk);
        idle(); wd_en = 1'b1; wd_addr = 10'd50;
        nr_we[0] = 1'b1; nr_waddr[0 +: AW] = 9'd50; nr_wdata[0 +: DW] = 32'h0000_0051;
        @(negedge clk);
        idle();
        check("R7 old data returned", wd_rdata, 32'h0000_0050);
        wide_read("R7 new data after", 10'd50, 32'h0000_0051);

        // R1: mid-run reset after a read request; contents survive
        @(negedge clk);
        idle(); wd_en = 1'b1; wd_addr = 10'd50; nr_re = 2'b11; rst = 1'b1;
        @(negedge clk);
        idle();
        check("R1 reset kills valids", {29'd0, nr_rvalid, wd_rvalid}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 valids low after reset", {29'd0, nr_rvalid, wd_rvalid}, 32'd0);
        wide_read("R1 contents kept", 10'd1023, 32'h3FF3_FF00);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule